// File: doc/BRIEF.md
# Colour Lookup Table Loader and Pixel Mapper

This block fills a colour lookup table from a stream of 16-bit words handed over on a valid/ready interface, the way a DMA channel would stream them out of memory. A start pulse samples a two-bit load-mode field, which selects one of three jobs: load the table only, skip the table and go straight to frame fetch, or load the table and then go on to frame fetch. The first table word carries a pixel-depth code in addition to the colour for entry 0. The depth code fixes how many table words are expected, and it also fixes how many index bits a pixel uses.

Once the table is loaded, indexed pixels arrive on a separate input and are turned into 12-bit RGB (4 bits each of red, green and blue) one cycle later. At the direct-colour depth the table is bypassed and the low 12 bits of the pixel go straight to the output. The block raises a one-cycle pulse when a table-only job finishes. It raises a different one-cycle pulse when frame fetch may begin. Fetching frame data and addressing memory are left to the surrounding logic.

Top module: `clut_sequencer`

## Requirements
- R1: On a start pulse, load_mode is sampled: 2'b01 loads the table only, 2'b00 loads the table and then starts frame fetch, 2'b10 accepts no words and pulses frame_go for one cycle in the cycle after start, and 2'b11 makes start have no effect.
- R2: Each accepted word (wd_valid and wd_ready high at a clock edge) writes its bits 11:0 into the next table entry, starting at entry 0. Red is in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R3: Bits 14:12 of the first accepted word of a load appear on depth in the cycle after that word. Code 0 is 1 bpp, 1 is 2 bpp, 2 is 4 bpp, 3 is 8 bpp and 4 is 12/16 bpp direct colour. The same bit field in later words is ignored, and depth holds until the next load.
- R4: A load expects 16 words when the depth code is 4 and 256 words for any other code. In table-only mode, pal_loaded is high for exactly one cycle, in the cycle after the last expected word is accepted, and is low before that.
- R5: In table-then-frame mode, frame_go pulses for one cycle in the cycle after the last word is accepted, and pal_loaded stays low.
- R6: The colour output is registered. rgb_valid and rgb follow pix_valid and pix one cycle later. The table index is the low 1, 2, 4 or 8 bits of pix for depth codes 0, 1, 2 and 3 respectively.
- R7: When depth is 4, rgb equals pix bits 11:0 and the table is not used.
- R8: wd_ready is high only from the cycle after an accepted start up to the last expected word. Words offered outside that window are not accepted and do not change the table or depth.
- R9: After reset, wd_ready, pal_loaded, frame_go and rgb_valid are low and depth is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_mode | input | 2 | Job select, sampled on start |
| start | input | 1 | Start pulse |
| wd_valid | input | 1 | Table word valid |
| wd_data | input | 16 | Table word: colour in 11:0, depth code in 14:12 of the first word |
| wd_ready | output | 1 | Block accepts a table word |
| pal_loaded | output | 1 | One-cycle pulse at the end of a table-only load |
| frame_go | output | 1 | One-cycle pulse allowing frame fetch to start |
| depth | output | 3 | Decoded depth code |
| pix_valid | input | 1 | Pixel valid |
| pix | input | 16 | Pixel value or table index |
| rgb_valid | output | 1 | Colour valid, one cycle after pix_valid |
| rgb | output | 12 | Colour output |

## Verification
The bench builds the block with its default parameters: a 256-entry table, a 16-entry short table for direct colour, 16-bit words and pixels, and the bypass path enabled. Because the table is full size, the bench can load all 256 entries (with stalls in the word stream) and confirm that the loaded pulse comes on the last word and not earlier. With the short table, the bench checks that a 16-word load ends after 16 words and that direct-colour pixels pass through unchanged. Index masking is checked at 1, 4 and 8 bits per pixel by feeding pixels whose upper bits are deliberately set.

// File: rtl/clut_pkg.sv
package clut_pkg;

   typedef enum logic [1:0] {
      LM_BOTH  = 2'b00,
      LM_PAL   = 2'b01,
      LM_FRAME = 2'b10,
      LM_NONE  = 2'b11
   } load_mode_e;

   localparam int          CODE_LSB     = 12;
   localparam int          CODE_W       = 3;
   localparam logic [2:0]  DEPTH_DIRECT = 3'd4;

   // number of pixel bits used as table index for a depth code
   function automatic int index_bits(input logic [2:0] code, input int idx_w);
      int n;
      case (code)
         3'd0:    n = 1;
         3'd1:    n = 2;
         3'd2:    n = 4;
         default: n = idx_w;
      endcase
      if (n > idx_w) n = idx_w;
      return n;
   endfunction

endpackage

// File: rtl/clut_load_ctrl.sv
module clut_load_ctrl
   import clut_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int COL_W         = 12,
   parameter int ENTRIES       = 256,
   parameter int SMALL_ENTRIES = 16,
   parameter int IDX_W         = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        load_mode,
   input  logic              start,
   input  logic              wd_valid,
   input  logic [DATA_W-1:0] wd_data,
   output logic              wd_ready,
   output logic              tbl_we,
   output logic [IDX_W-1:0]  tbl_waddr,
   output logic [COL_W-1:0]  tbl_wdata,
   output logic [2:0]        depth,
   output logic              pal_loaded,
   output logic              frame_go
);

   localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(ENTRIES - 1);
   localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(SMALL_ENTRIES - 1);

   typedef enum logic {S_IDLE, S_LOAD} st_e;

   st_e              st_q;
   load_mode_e       mode_q;
   logic [IDX_W-1:0] cnt_q;
   logic [2:0]       depth_q;
   logic             accept;
   logic             first_w;
   logic [2:0]       code_now;
   logic [IDX_W-1:0] last_idx;
   logic             done;
   logic             start_tbl;
   logic             start_frm;

   assign wd_ready  = (st_q == S_LOAD);
   assign accept    = wd_valid && wd_ready;
   assign first_w   = (cnt_q == '0);
   assign code_now  = first_w ? wd_data[CODE_LSB +: CODE_W] : depth_q;
   assign last_idx  = (code_now == DEPTH_DIRECT) ? LAST_SMALL : LAST_FULL;
   assign done      = accept && (cnt_q == last_idx);
   assign start_tbl = start && (st_q == S_IDLE) &&
                      ((load_mode == LM_PAL) || (load_mode == LM_BOTH));
   assign start_frm = start && (st_q == S_IDLE) && (load_mode == LM_FRAME);

   assign tbl_we    = accept;
   assign tbl_waddr = cnt_q;
   assign tbl_wdata = wd_data[COL_W-1:0];
   assign depth     = depth_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         mode_q     <= LM_NONE;
         cnt_q      <= '0;
         depth_q    <= '0;
         pal_loaded <= 1'b0;
         frame_go   <= 1'b0;
      end else begin
         pal_loaded <= done && (mode_q == LM_PAL);
         frame_go   <= (done && (mode_q == LM_BOTH)) || start_frm;
         if (start_tbl) begin
            st_q   <= S_LOAD;
            mode_q <= load_mode_e'(load_mode);
            cnt_q  <= '0;
         end else if (accept) begin
            if (first_w)
               depth_q <= wd_data[CODE_LSB +: CODE_W];
            if (done) begin
               st_q  <= S_IDLE;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_LOADED_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      pal_loaded |-> $past(wd_valid && wd_ready)); // R4
   AST_LOADED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pal_loaded |=> !pal_loaded); // R4
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pal_loaded, frame_go})); // R5
   AST_DEPTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wd_valid && wd_ready) |=> $stable(depth)); // R3
   AST_READY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wd_ready) && !wd_ready) |-> (pal_loaded || frame_go)); // R8

endmodule

// File: rtl/clut_store.sv
module clut_store #(
   parameter int COL_W   = 12,
   parameter int ENTRIES = 256,
   parameter int IDX_W   = 8
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [COL_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [COL_W-1:0] rdata
);

   logic [COL_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/clut_pixel_map.sv
module clut_pixel_map
   import clut_pkg::*;
#(
   parameter int PIX_W     = 16,
   parameter int COL_W     = 12,
   parameter int IDX_W     = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       depth,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix,
   output logic [IDX_W-1:0] raddr,
   input  logic [COL_W-1:0] rdata,
   output logic             rgb_valid,
   output logic [COL_W-1:0] rgb
);

   int               nbits;
   logic [COL_W-1:0] col_sel;

   assign nbits = index_bits(depth, IDX_W);

   for (genvar b = 0; b < IDX_W; b++) begin : g_idx
      assign raddr[b] = pix[b] & (b < nbits);
   end

   if (BYPASS_EN) begin : g_bypass
      assign col_sel = (depth == DEPTH_DIRECT) ? pix[COL_W-1:0] : rdata;
   end else begin : g_table_only
      assign col_sel = rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rgb_valid <= 1'b0;
         rgb       <= '0;
      end else begin
         rgb_valid <= pix_valid;
         rgb       <= col_sel;
      end
   end

   AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rgb_valid == $past(pix_valid))); // R6

   if (BYPASS_EN) begin : g_bypass_chk
      AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (pix_valid && depth == DEPTH_DIRECT) |=> (rgb == $past(pix[COL_W-1:0]))); // R7
   end

endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
   import clut_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int COL_W         = 12,
   parameter int PIX_W         = 16,
   parameter int ENTRIES       = 256,
   parameter int SMALL_ENTRIES = 16,
   parameter bit BYPASS_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        load_mode,
   input  logic              start,
   input  logic              wd_valid,
   input  logic [DATA_W-1:0] wd_data,
   output logic              wd_ready,
   output logic              pal_loaded,
   output logic              frame_go,
   output logic [2:0]        depth,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix,
   output logic              rgb_valid,
   output logic [COL_W-1:0]  rgb
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES != (1 << IDX_W)) begin : g_chk_pow2
      $error("ENTRIES must be a power of two");
   end
   if (SMALL_ENTRIES < 2 || SMALL_ENTRIES > ENTRIES) begin : g_chk_small
      $error("SMALL_ENTRIES must lie in 2..ENTRIES");
   end
   if (DATA_W < CODE_LSB + CODE_W || COL_W > CODE_LSB) begin : g_chk_word
      $error("word too narrow for colour plus depth code");
   end
   if (PIX_W < COL_W || PIX_W < IDX_W) begin : g_chk_pix
      $error("pixel narrower than colour or index");
   end

   logic             tbl_we;
   logic [IDX_W-1:0] tbl_waddr;
   logic [COL_W-1:0] tbl_wdata;
   logic [IDX_W-1:0] tbl_raddr;
   logic [COL_W-1:0] tbl_rdata;

   clut_load_ctrl #(
      .DATA_W(DATA_W), .COL_W(COL_W), .ENTRIES(ENTRIES),
      .SMALL_ENTRIES(SMALL_ENTRIES), .IDX_W(IDX_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .start(start),
      .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
      .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
      .depth(depth), .pal_loaded(pal_loaded), .frame_go(frame_go)
   );

   clut_store #(.COL_W(COL_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_store (
      .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
      .raddr(tbl_raddr), .rdata(tbl_rdata)
   );

   clut_pixel_map #(
      .PIX_W(PIX_W), .COL_W(COL_W), .IDX_W(IDX_W), .BYPASS_EN(BYPASS_EN)
   ) i_map (
      .clk(clk), .rst_n(rst_n), .depth(depth), .pix_valid(pix_valid),
      .pix(pix), .raddr(tbl_raddr), .rdata(tbl_rdata),
      .rgb_valid(rgb_valid), .rgb(rgb)
   );

endmodule

// File: tb/test_clut_sequencer.sv
module test_clut_sequencer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  load_mode;
   logic        start;
   logic        wd_valid;
   logic [15:0] wd_data;
   logic        wd_ready;
   logic        pal_loaded;
   logic        frame_go;
   logic [2:0]  depth;
   logic        pix_valid;
   logic [15:0] pix;
   logic        rgb_valid;
   logic [11:0] rgb;

   int checks   = 0;
   int failures = 0;

   always #5 clk = ~clk;

   clut_sequencer i_clut_sequencer (
      .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .start(start),
      .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
      .pal_loaded(pal_loaded), .frame_go(frame_go), .depth(depth),
      .pix_valid(pix_valid), .pix(pix), .rgb_valid(rgb_valid), .rgb(rgb)
   );

   // {pixel, expected colour} for the 8 bpp table colour f(i) = i*37+5
   localparam logic [27:0] VEC [6] = '{
      {16'h0000, 12'h005}, {16'h0001, 12'h02A}, {16'h0002, 12'h04F},
      {16'h00FF, 12'h4E0}, {16'h0080, 12'h285}, {16'h1234, 12'h789}
   };

   function automatic logic [11:0] col(input int fsel, input int i);
      case (fsel)
         0:       col = 12'((i * 37) + 5);
         1:       col = 12'((i * 5) + 12'h300);
         2:       col = 12'(12'h0F0 + i);
         default: col = 12'(12'hA00 + i);
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // starts a load and streams n words; returns at the negedge after the last accept
   task automatic load_tbl(input logic [1:0] mode, input logic [2:0] code, input int n,
                           input int fsel, input bit gaps, output bit early);
      early = 1'b0;
      @(negedge clk);
      load_mode = mode;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 3 == 1)) begin
            wd_valid = 1'b0;
            @(negedge clk);
         end
         if (!wd_ready || pal_loaded || frame_go) early = 1'b1;
         wd_valid = 1'b1;
         wd_data  = {1'b1, (i == 0) ? code : 3'b111, col(fsel, i)};
         @(negedge clk);
      end
      wd_valid = 1'b0;
   endtask

   task automatic lookup(input logic [15:0] p, input logic [11:0] exp, input string req);
      @(negedge clk);
      pix_valid = 1'b1;
      pix       = p;
      @(negedge clk);
      pix_valid = 1'b0;
      chk(req, {20'd0, rgb}, {20'd0, exp});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit early;
      rst_n = 1'b0; load_mode = 2'b11; start = 1'b0; wd_valid = 1'b0;
      wd_data = '0; pix_valid = 1'b0; pix = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 ready", {31'd0, wd_ready}, 0);
      chk("R9 loaded", {31'd0, pal_loaded}, 0);
      chk("R9 frame_go", {31'd0, frame_go}, 0);
      chk("R9 rgb_valid", {31'd0, rgb_valid}, 0);
      chk("R9 depth", {29'd0, depth}, 0);

      // R4 R2 R3: 8 bpp table-only load with stalls
      load_tbl(2'b01, 3'd3, 256, 0, 1'b1, early);
      chk("R4 no early pulse", {31'd0, early}, 0);
      chk("R4 loaded pulse", {31'd0, pal_loaded}, 1);
      chk("R5 no frame_go in table-only", {31'd0, frame_go}, 0);
      chk("R3 depth 8bpp", {29'd0, depth}, 3);
      @(negedge clk);
      chk("R4 pulse one cycle", {31'd0, pal_loaded}, 0);
      chk("R8 ready low after load", {31'd0, wd_ready}, 0);

      // R6 R2 table walk
      for (int v = 0; v < 6; v++)
         lookup(VEC[v][27:12], VEC[v][11:0], "R6 8bpp lookup");

      // R8 words after the load are ignored
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         wd_valid = 1'b1;
         wd_data  = 16'hCFFF;
      end
      @(negedge clk);
      wd_valid = 1'b0;
      chk("R8 ready stays low", {31'd0, wd_ready}, 0);
      chk("R8 depth unchanged", {29'd0, depth}, 3);
      lookup(16'h0000, 12'h005, "R8 entry 0 unchanged");

      // R6 latency: valid drops one cycle after pix_valid drops
      @(negedge clk);
      chk("R6 valid follows", {31'd0, rgb_valid}, 0);

      // R5 table then frame, 4 bpp
      load_tbl(2'b00, 3'd2, 256, 1, 1'b0, early);
      chk("R5 no early pulse", {31'd0, early}, 0);
      chk("R5 frame_go", {31'd0, frame_go}, 1);
      chk("R5 no loaded pulse", {31'd0, pal_loaded}, 0);
      chk("R3 depth 4bpp", {29'd0, depth}, 2);
      lookup(16'h00F7, col(1, 7), "R6 4bpp mask");
      lookup(16'h0010, col(1, 0), "R6 4bpp upper bits dropped");

      // R6 1 bpp
      load_tbl(2'b01, 3'd0, 256, 2, 1'b0, early);
      chk("R3 depth 1bpp", {29'd0, depth}, 0);
      lookup(16'h00FF, col(2, 1), "R6 1bpp mask");

      // R4 R7 direct colour: 16-word load then bypass
      load_tbl(2'b01, 3'd4, 16, 3, 1'b1, early);
      chk("R4 short load no early pulse", {31'd0, early}, 0);
      chk("R4 short load pulse", {31'd0, pal_loaded}, 1);
      chk("R3 depth direct", {29'd0, depth}, 4);
      chk("R8 ready low after 16", {31'd0, wd_ready}, 0);
      lookup(16'hABCD, 12'hBCD, "R7 bypass");
      lookup(16'h0003, 12'h003, "R7 bypass small");

      // R1 frame-only
      @(negedge clk);
      load_mode = 2'b10;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 frame-only pulse", {31'd0, frame_go}, 1);
      chk("R1 frame-only no ready", {31'd0, wd_ready}, 0);
      @(negedge clk);
      chk("R1 frame-only single", {31'd0, frame_go}, 0);

      // R1 mode 11 ignored
      load_mode = 2'b11;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 mode 11 no ready", {31'd0, wd_ready}, 0);
      chk("R1 mode 11 no frame_go", {31'd0, frame_go}, 0);
      @(negedge clk);
      chk("R1 mode 11 no loaded", {31'd0, pal_loaded}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule